// File: doc/BRIEF.md
# Per-Task Paged Address Translator

This block sits between a small processor's data port and its data RAM. Several tasks share the RAM, and each task addresses its own private space that starts at address zero. The physical RAM is cut into equal pages. A page table has one entry per physical page, and each entry names the task that owns the page and the virtual page number under which that task sees it. On every access the upper virtual bits, taken together with the current task number, are matched against all entries at once. The index of the entry that matches becomes the physical page number, and the lower virtual bits pass through unchanged as the offset.

Accesses that match no entry are rejected. A rejected write never reaches the RAM. A rejected read returns zero. In both cases a fault pulse is raised. The page table is loaded through a separate configuration write port. The policy that decides which pages go to which task is outside this block, and so is the RAM.

Top module: `task_page_xlate`

## Requirements
- R1: After reset every table entry is invalid, so the first access from any task is rejected, and with no access pending `acc_fault` and `mem_req` are low.
- R2: A valid entry at index P whose owner equals `task_id` and whose page number equals `acc_vaddr[7:4]` accepts the access in the same cycle. It drives `mem_req` high and `mem_addr = {P[4:0], acc_vaddr[3:0]}`, and this also holds for virtual address 0x00 and for the top page and offset 0xFF.
- R3: An entry owned by one task never matches an access from another task that uses the same virtual page number.
- R4: An entry whose valid bit is 0 never matches, even when its owner and page number both equal those of the access.
- R5: A rejected access drives `mem_req` and `mem_we` low and `mem_addr` to 0, so a rejected write leaves RAM contents unchanged.
- R6: One cycle after a rejected read, `acc_rdata` is 0 whatever value `mem_rdata` carries.
- R7: One cycle after an accepted read, `acc_rdata` equals `mem_rdata` (the RAM has one cycle of read latency). One cycle after an idle cycle or a write, `acc_rdata` is 0.
- R8: `acc_fault` is high for exactly the cycle that follows each rejected access, and low after accepted accesses and idle cycles.
- R9: A configuration write with `cfg_we` high sets entry `cfg_idx` to {`cfg_valid`, `cfg_tid`, `cfg_vpn`} at the clock edge, and accesses in later cycles use the new contents. This covers both invalidating an entry and moving it to another owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Physical page whose entry is written |
| cfg_valid | input | 1 | Valid bit for the entry |
| cfg_tid | input | 3 | Owner task of the entry |
| cfg_vpn | input | 4 | Virtual page number under which the owner sees the page |
| task_id | input | 3 | Task issuing the current access |
| acc_req | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_vaddr | input | 8 | Task-relative virtual address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, one cycle after the access |
| acc_fault | output | 1 | Rejected-access pulse, one cycle after the access |
| mem_req | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 9 | Physical RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after `mem_req` |

## Verification
Translation is tried at both ends of the virtual space, at address 0x00 and at 0xFF, which tells apart a correct page-index encode from an off-by-one or truncated one. Two tasks are given the same virtual page number, so that a match on page number alone is caught. A fully matching entry with its valid bit cleared catches a match that ignores validity. Misses are issued while `mem_rdata` still holds a nonzero value from an earlier read, which shows whether read gating is present. Writes are read back, which shows whether blocked writes really leave the RAM unchanged. Invalidating and remapping an entry shows that configuration writes take effect in the cycle after they are made.

// File: rtl/xlate_pkg.sv
// Shared constants and types for the per-task paged address translator.
package xlate_pkg;
    localparam int XL_VA_W   = 8;
    localparam int XL_VPN_W  = 4;
    localparam int XL_PAGES  = 32;
    localparam int XL_TID_W  = 3;
    localparam int XL_DATA_W = 8;

    // Outcome of the access presented in the current cycle.
    typedef enum logic [1:0] {
        XL_IDLE   = 2'd0,
        XL_PASS   = 2'd1,
        XL_REJECT = 2'd2
    } xl_outcome_e;
endpackage

// File: rtl/xlate_page_table.sv
// Page table storage: one entry per physical page, holding a valid bit,
// an owner task and a virtual page number. It is written only through
// the configuration port. Assumes software keeps at most one valid
// entry per (task, virtual page) pair.
module xlate_page_table #(
    parameter int PAGES  = xlate_pkg::XL_PAGES,
    parameter int TID_W  = xlate_pkg::XL_TID_W,
    parameter int VPN_W  = xlate_pkg::XL_VPN_W,
    localparam int IDX_W = $clog2(PAGES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic                         cfg_valid,
    input  logic [TID_W-1:0]             cfg_tid,
    input  logic [VPN_W-1:0]             cfg_vpn,
    output logic [PAGES-1:0]             ent_valid,
    output logic [PAGES-1:0][TID_W-1:0]  ent_tid,
    output logic [PAGES-1:0][VPN_W-1:0]  ent_vpn
);
    genvar g;
    generate
        for (g = 0; g < PAGES; g++) begin : g_ent
            // Update entry g on a matching configuration write; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_valid[g] <= 1'b0;
                    ent_tid[g]   <= '0;
                    ent_vpn[g]   <= '0;
                end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                    ent_valid[g] <= cfg_valid;
                    ent_tid[g]   <= cfg_tid;
                    ent_vpn[g]   <= cfg_vpn;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/xlate_match.sv
// Parallel lookup: compares (task, virtual page) against every entry and
// encodes the index of the hit as the physical page number. Assumes at
// most one entry hits; if several do, the index bits are OR-ed together.
module xlate_match #(
    parameter int PAGES  = xlate_pkg::XL_PAGES,
    parameter int TID_W  = xlate_pkg::XL_TID_W,
    parameter int VPN_W  = xlate_pkg::XL_VPN_W,
    localparam int IDX_W = $clog2(PAGES)
) (
    input  logic [PAGES-1:0]             ent_valid,
    input  logic [PAGES-1:0][TID_W-1:0]  ent_tid,
    input  logic [PAGES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [TID_W-1:0]             task_id,
    input  logic [VPN_W-1:0]             vpn,
    output logic                         hit,
    output logic [IDX_W-1:0]             ppn
);
    logic [PAGES-1:0] hit_vec;

    genvar g;
    generate
        for (g = 0; g < PAGES; g++) begin : g_cmp
            // Entry g hits when it is valid and both keys are equal.
            always_comb hit_vec[g] = ent_valid[g] && (ent_tid[g] == task_id)
                                     && (ent_vpn[g] == vpn);
        end
    endgenerate

    // Encode the hit vector into a page index and an overall hit flag.
    always_comb begin
        ppn = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (hit_vec[i]) ppn = ppn | IDX_W'(i);
        end
        hit = |hit_vec;
    end
endmodule

// File: rtl/xlate_gate.sv
// Access gate: forwards accepted accesses to RAM, blocks rejected ones,
// and zeroes read data and raises a fault pulse one cycle after a
// rejected access. Assumes the RAM has one cycle of read latency.
module xlate_gate #(
    parameter int IDX_W  = 5,
    parameter int OFF_W  = 4,
    parameter int DATA_W = xlate_pkg::XL_DATA_W,
    localparam int PA_W  = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [OFF_W-1:0]  offset,
    input  logic              hit,
    input  logic [IDX_W-1:0]  ppn,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_fault
);
    import xlate_pkg::*;

    xl_outcome_e outcome;
    logic        rd_ok_q;
    logic        fault_q;

    // Classify the current access.
    always_comb begin
        if (!acc_req)  outcome = XL_IDLE;
        else if (hit)  outcome = XL_PASS;
        else           outcome = XL_REJECT;
    end

    // Drive the RAM side only for accepted accesses.
    always_comb begin
        mem_req   = (outcome == XL_PASS);
        mem_we    = (outcome == XL_PASS) && acc_we;
        mem_addr  = (outcome == XL_PASS) ? {ppn, offset} : '0;
        mem_wdata = acc_wdata;
    end

    // Remember whether the previous access was an accepted read or a rejection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ok_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            rd_ok_q <= (outcome == XL_PASS) && !acc_we;
            fault_q <= (outcome == XL_REJECT);
        end
    end

    // Pass RAM data only after an accepted read.
    always_comb begin
        acc_rdata = rd_ok_q ? mem_rdata : '0;
        acc_fault = fault_q;
    end
endmodule

// File: rtl/task_page_xlate.sv
// Top of the per-task paged address translator. It splits the virtual
// address into page number and offset, looks the page up for the current
// task, and gates the RAM access on the result. Assumes a unique hit.
module task_page_xlate #(
    parameter int VA_W   = xlate_pkg::XL_VA_W,
    parameter int VPN_W  = xlate_pkg::XL_VPN_W,
    parameter int PAGES  = xlate_pkg::XL_PAGES,
    parameter int TID_W  = xlate_pkg::XL_TID_W,
    parameter int DATA_W = xlate_pkg::XL_DATA_W,
    localparam int OFF_W = VA_W - VPN_W,
    localparam int IDX_W = $clog2(PAGES),
    localparam int PA_W  = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [TID_W-1:0]  cfg_tid,
    input  logic [VPN_W-1:0]  cfg_vpn,
    input  logic [TID_W-1:0]  task_id,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [VA_W-1:0]   acc_vaddr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [PAGES-1:0]            ent_valid;
    logic [PAGES-1:0][TID_W-1:0] ent_tid;
    logic [PAGES-1:0][VPN_W-1:0] ent_vpn;
    logic                        hit;
    logic [IDX_W-1:0]            ppn;

    xlate_page_table #(.PAGES(PAGES), .TID_W(TID_W), .VPN_W(VPN_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_tid(cfg_tid), .cfg_vpn(cfg_vpn),
        .ent_valid(ent_valid), .ent_tid(ent_tid), .ent_vpn(ent_vpn)
    );

    xlate_match #(.PAGES(PAGES), .TID_W(TID_W), .VPN_W(VPN_W)) u_match (
        .ent_valid(ent_valid), .ent_tid(ent_tid), .ent_vpn(ent_vpn),
        .task_id(task_id), .vpn(acc_vaddr[VA_W-1:OFF_W]),
        .hit(hit), .ppn(ppn)
    );

    xlate_gate #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_we(acc_we), .offset(acc_vaddr[OFF_W-1:0]),
        .hit(hit), .ppn(ppn), .acc_wdata(acc_wdata), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .acc_rdata(acc_rdata), .acc_fault(acc_fault)
    );
endmodule

// File: rtl/xlate_checker.sv
// Port-level properties of the translator, attached by bind.
module xlate_checker #(
    parameter int VA_W   = 8,
    parameter int OFF_W  = 4,
    parameter int PA_W   = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_req,
    input logic              acc_we,
    input logic [VA_W-1:0]   acc_vaddr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [PA_W-1:0]   mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              acc_fault
);
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[OFF_W-1:0] == acc_vaddr[OFF_W-1:0]);

    a_r5_no_write_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    a_r5_req_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> acc_req);

    a_r8_fault_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !mem_req) |=> acc_fault);

    a_r8_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_req || mem_req) |=> !acc_fault);

    a_r6_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> acc_rdata == '0);

    a_r7_read_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !acc_we) |=> acc_rdata == mem_rdata);
endmodule

bind task_page_xlate xlate_checker #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_vaddr(acc_vaddr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .acc_rdata(acc_rdata),
    .acc_fault(acc_fault)
);

// File: tb/task_page_xlate_bench.sv
`timescale 1ns/1ps
module task_page_xlate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_idx = '0;
    logic       cfg_valid = 1'b0;
    logic [2:0] cfg_tid = '0;
    logic [3:0] cfg_vpn = '0;
    logic [2:0] task_id = '0;
    logic       acc_req = 1'b0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_vaddr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       acc_fault;
    logic       mem_req;
    logic       mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic       exp_fault;
        logic [7:0] exp_rdata;
        string      tag;
    } sb_item_t;
    sb_item_t sbq[$];

    logic [7:0] ram    [512];
    logic [7:0] shadow [512];

    always #5 clk = ~clk;

    task_page_xlate u_task_page_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_tid(cfg_tid), .cfg_vpn(cfg_vpn),
        .task_id(task_id), .acc_req(acc_req), .acc_we(acc_we),
        .acc_vaddr(acc_vaddr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_fault(acc_fault), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // RAM model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: compares registered outputs against the expected queue.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                check(acc_fault == it.exp_fault, {it.tag, " fault"}, acc_fault, it.exp_fault);
                check(acc_rdata == it.exp_rdata, {it.tag, " rdata"}, acc_rdata, it.exp_rdata);
            end
        end
    end

    task automatic idle(input string tag);
        @(negedge clk);
        cfg_we = 1'b0; acc_req = 1'b0; acc_we = 1'b0;
        sbq.push_back('{1'b0, 8'h00, tag});
    endtask

    task automatic cfg(input [4:0] idx, input bit v, input [2:0] tid, input [3:0] vpn);
        @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0;
        cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v; cfg_tid = tid; cfg_vpn = vpn;
        sbq.push_back('{1'b0, 8'h00, "R9 cfg cycle"});
    endtask

    task automatic acc(input [2:0] tid, input bit we, input [7:0] va, input [7:0] wd,
                       input bit exp_hit, input [4:0] exp_ppn, input string tag);
        logic [8:0] pa;
        logic [7:0] er;
        @(negedge clk);
        cfg_we = 1'b0;
        task_id = tid; acc_req = 1'b1; acc_we = we; acc_vaddr = va; acc_wdata = wd;
        #1;
        pa = exp_hit ? {exp_ppn, va[3:0]} : 9'h000;
        check(mem_req == exp_hit, {tag, " mem_req"}, mem_req, exp_hit);
        check(mem_we == (exp_hit && we), {tag, " mem_we"}, mem_we, exp_hit && we);
        check(mem_addr == pa, {tag, " mem_addr"}, mem_addr, pa);
        er = (exp_hit && !we) ? shadow[pa] : 8'h00;
        if (exp_hit && we) shadow[pa] = wd;
        sbq.push_back('{!exp_hit, er, tag});
    endtask

    // Watchdog.
    initial begin
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Driver: stimulus sequence.
    initial begin
        for (int i = 0; i < 512; i++) begin
            ram[i]    = 8'((i * 7) + 3);
            shadow[i] = 8'((i * 7) + 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(acc_fault == 1'b0, "R1 reset fault", acc_fault, 0);
        check(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);
        acc(3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 5'd0, "R1 empty table read");
        acc(3'd1, 1'b1, 8'h10, 8'h77, 1'b0, 5'd0, "R1 empty table write");

        cfg(5'd5,  1'b1, 3'd1, 4'h0);
        cfg(5'd17, 1'b1, 3'd1, 4'h3);
        cfg(5'd9,  1'b1, 3'd2, 4'h0);
        cfg(5'd30, 1'b0, 3'd4, 4'hF);
        cfg(5'd31, 1'b1, 3'd7, 4'hF);
        idle("R8 idle");

        acc(3'd1, 1'b0, 8'h00, 8'h00, 1'b1, 5'd5,  "R2 task1 va00");
        acc(3'd1, 1'b0, 8'h3A, 8'h00, 1'b1, 5'd17, "R2 task1 va3A");
        acc(3'd7, 1'b0, 8'hFF, 8'h00, 1'b1, 5'd31, "R2 task7 vaFF");
        acc(3'd1, 1'b1, 8'h37, 8'hA5, 1'b1, 5'd17, "R7 write");
        acc(3'd1, 1'b0, 8'h37, 8'h00, 1'b1, 5'd17, "R7 readback");
        acc(3'd2, 1'b0, 8'h00, 8'h00, 1'b1, 5'd9,  "R3 task2 va00");
        acc(3'd2, 1'b0, 8'h37, 8'h00, 1'b0, 5'd0,  "R3 R6 task2 foreign page");
        acc(3'd4, 1'b0, 8'hF0, 8'h00, 1'b0, 5'd0,  "R4 invalid entry");
        acc(3'd3, 1'b1, 8'h20, 8'h55, 1'b0, 5'd0,  "R5 blocked write");
        acc(3'd1, 1'b0, 8'h3A, 8'h00, 1'b1, 5'd17, "R8 hit after miss");
        idle("R8 idle after read");

        cfg(5'd5, 1'b0, 3'd1, 4'h0);
        acc(3'd1, 1'b0, 8'h05, 8'h00, 1'b0, 5'd0,  "R9 invalidated");
        cfg(5'd5, 1'b1, 3'd3, 4'h2);
        acc(3'd3, 1'b0, 8'h2C, 8'h00, 1'b1, 5'd5,  "R9 remapped");
        acc(3'd1, 1'b0, 8'h2C, 8'h00, 1'b0, 5'd0,  "R9 R3 old owner");
        acc(3'd3, 1'b1, 8'h20, 8'h5A, 1'b1, 5'd5,  "R5 R9 write now mapped");
        acc(3'd3, 1'b0, 8'h20, 8'h00, 1'b1, 5'd5,  "R5 R7 readback");
        idle("R8 final idle");
        idle("R8 final idle 2");

        while (sbq.size() > 0) @(posedge clk);
        #5;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule